// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level paging structure from memory. It accepts one translation request at a time. It reads the first-level (directory) entry that covers the 4 MiB region of the address. That entry either points to a 4 KiB-aligned second-level table, in which case the walker reads one table entry, or it maps a 4 MiB page directly when large pages are enabled.

Presence and access rights are checked at every level that is used. The user and write permissions of the two levels are combined. When the access is allowed, the walker sets the accessed flag in each entry it used by writing the entry back. The response carries the physical address and the write-through and cache-disable flags of the final entry. If the access is refused, the response carries a three-bit fault code instead.

All entries share one flag layout. Bit 0 is present, bit 1 is writable, bit 2 is user, bit 3 is write-through, bit 4 is cache-disable, bit 5 is accessed and bit 7 is page-size. Bits 9 to 11 belong to software. The upper 20 bits hold the next base address.

Top module: `pgwalk`

## Requirements
- R1: The first memory read of every walk is at `{cfg_dir_base[31:12], vaddr[31:22], 2'b00}`.
- R2: For a table walk, the second read is at `{dir_entry[31:12], vaddr[21:12], 2'b00}`, and the translation is `{tbl_entry[31:12], vaddr[11:0]}`.
- R3: When directory bit 7 is set and `cfg_large_en` is 1, no table read occurs and the translation is `{dir_entry[31:22], vaddr[21:0]}`. When `cfg_large_en` is 0, bit 7 is ignored and the table is walked.
- R4: An entry with bit 0 clear ends the walk with a not-present fault. No further read and no write follow, and the other bits of that entry have no effect.
- R5: A user access needs bit 2 set in both the directory entry and the table entry. A large page checks only the directory entry.
- R6: A write needs bit 1 set at every level used. For a supervisor write, a clear bit 1 faults only when `cfg_wp` is 1.
- R7: After a permitted access, each entry used that has bit 5 clear is written back once, unchanged except that bit 5 is set. The directory entry is written before the table entry. A fault writes nothing.
- R8: `rsp_fcode` bit 0 is 1 for a protection fault and 0 for not-present. Bit 1 copies the request's write flag and bit 2 copies its user flag. On a fault, `rsp_paddr`, `rsp_wt` and `rsp_cd` are 0. On success, `rsp_fault` and `rsp_fcode` are 0.
- R9: Bits 9 to 11 of either entry do not change the response, the reads or the writes, apart from the written-back data.
- R10: On success, `rsp_wt` and `rsp_cd` are bits 3 and 4 of the final entry.
- R11: `req_ready` is high only when idle. A memory read holds its address until `mem_rvalid`. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dir_base | input | 32 | Directory base; bits 11:0 ignored |
| cfg_large_en | input | 1 | Enables 4 MiB pages |
| cfg_wp | input | 1 | Makes read-only binding on supervisor writes |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation refused |
| rsp_fcode | output | 3 | {user, write, protection} |
| rsp_paddr | output | 32 | Physical address |
| rsp_wt | output | 1 | Write-through attribute |
| rsp_cd | output | 1 | Cache-disable attribute |
| mem_rd | output | 1 | Entry read request, held until mem_rvalid |
| mem_wr | output | 1 | Entry write-back, one cycle |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach is a permitted table walk where both entries lack the accessed flag. Only this case produces two write-backs in order, and it needs bit 0, the permission bits of both levels and bit 5 of both entries lined up at once. Directed cases build that pair explicitly. Random stimulus forces bit 0 high most of the time and draws the other flags at random, so that combined-permission outcomes, large pages with the enable off, and partial write-backs all occur many times. The memory model's latency varies between reads, which also tests the read hold.

// File: rtl/pgwalk.sv
module pgwalk #(
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENT_W-1:0] cfg_dir_base,
  input  logic             cfg_large_en,
  input  logic             cfg_wp,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ENT_W-1:0] req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [2:0]       rsp_fcode,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic             rsp_wt,
  output logic             rsp_cd,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [ENT_W-1:0] mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_rvalid,
  input  logic [ENT_W-1:0] mem_rdata
);
  localparam int F_P  = 0;
  localparam int F_RW = 1;
  localparam int F_US = 2;
  localparam int F_WT = 3;
  localparam int F_CD = 4;
  localparam int F_AC = 5;
  localparam int F_PS = 7;
  localparam logic [ENT_W-1:0] AC_MASK = ENT_W'(1) << F_AC;

  typedef enum logic [2:0] {S_IDLE, S_DRD, S_TRD, S_DWB, S_TWB, S_RSP} st_t;

  st_t              st;
  logic [ENT_W-1:0] va_q, pde_q, pte_q, pa_q;
  logic             wr_q, usr_q, large_q, flt_q, prot_q, wt_q, cd_q;

  function automatic logic deny(input logic us, input logic rw, input logic u,
                                input logic w, input logic wp);
    return (u && !us) || (w && !rw && (u || wp));
  endfunction

  logic lg_hit, lg_deny, tb_deny;
  assign lg_hit  = mem_rdata[F_PS] && cfg_large_en;
  assign lg_deny = deny(mem_rdata[F_US], mem_rdata[F_RW], usr_q, wr_q, cfg_wp);
  assign tb_deny = deny(pde_q[F_US] & mem_rdata[F_US], pde_q[F_RW] & mem_rdata[F_RW],
                        usr_q, wr_q, cfg_wp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; pde_q <= '0; pte_q <= '0; pa_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; large_q <= 1'b0;
      flt_q <= 1'b0; prot_q <= 1'b0; wt_q <= 1'b0; cd_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr; wr_q <= req_write; usr_q <= req_user;
          flt_q <= 1'b0; prot_q <= 1'b0; pa_q <= '0; wt_q <= 1'b0; cd_q <= 1'b0;
          st <= S_DRD;
        end
        S_DRD: if (mem_rvalid) begin
          pde_q <= mem_rdata;
          large_q <= lg_hit;
          if (!mem_rdata[F_P]) begin
            flt_q <= 1'b1; prot_q <= 1'b0; st <= S_RSP;
          end else if (lg_hit) begin
            if (lg_deny) begin
              flt_q <= 1'b1; prot_q <= 1'b1; st <= S_RSP;
            end else begin
              pa_q <= {mem_rdata[ENT_W-1:22], va_q[21:0]};
              wt_q <= mem_rdata[F_WT]; cd_q <= mem_rdata[F_CD];
              st <= mem_rdata[F_AC] ? S_RSP : S_DWB;
            end
          end else begin
            st <= S_TRD;
          end
        end
        S_TRD: if (mem_rvalid) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[F_P]) begin
            flt_q <= 1'b1; prot_q <= 1'b0; st <= S_RSP;
          end else if (tb_deny) begin
            flt_q <= 1'b1; prot_q <= 1'b1; st <= S_RSP;
          end else begin
            pa_q <= {mem_rdata[ENT_W-1:12], va_q[11:0]};
            wt_q <= mem_rdata[F_WT]; cd_q <= mem_rdata[F_CD];
            if (!pde_q[F_AC])          st <= S_DWB;
            else if (!mem_rdata[F_AC]) st <= S_TWB;
            else                       st <= S_RSP;
          end
        end
        S_DWB: st <= (!large_q && !pte_q[F_AC]) ? S_TWB : S_RSP;
        S_TWB: st <= S_RSP;
        S_RSP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [ENT_W-1:0] dir_addr, tbl_addr;
  assign dir_addr = {cfg_dir_base[ENT_W-1:12], va_q[31:22], 2'b00};
  assign tbl_addr = {pde_q[ENT_W-1:12], va_q[21:12], 2'b00};

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_DRD) || (st == S_TRD);
  assign mem_wr    = (st == S_DWB) || (st == S_TWB);
  assign mem_addr  = (st == S_DRD || st == S_DWB) ? dir_addr :
                     (st == S_TRD || st == S_TWB) ? tbl_addr : '0;
  assign mem_wdata = (st == S_DWB) ? (pde_q | AC_MASK) :
                     (st == S_TWB) ? (pte_q | AC_MASK) : '0;

  assign rsp_valid = (st == S_RSP);
  assign rsp_fault = flt_q;
  assign rsp_fcode = flt_q ? {usr_q, wr_q, prot_q} : 3'b000;
  assign rsp_paddr = pa_q;
  assign rsp_wt    = wt_q;
  assign rsp_cd    = cd_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_paddr,
  input logic        rsp_wt,
  input logic        rsp_cd,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_rvalid,
  input logic [31:0] va_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd && !mem_wr && !rsp_valid)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr))); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R11
  AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[5] && mem_wdata[0])); // R7
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0 && !rsp_wt && !rsp_cd)); // R8
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == va_q[11:0])); // R2
endmodule

bind pgwalk pgwalk_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_wt(rsp_wt), .rsp_cd(rsp_cd),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rvalid(mem_rvalid), .va_q(va_q)
);

// File: tb/pgwalk_tb_top.sv
module pgwalk_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_dir_base = 32'h0012_3000;
  logic cfg_large_en = 1'b0, cfg_wp = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_wt, rsp_cd, mem_rd, mem_wr;
  logic [2:0] rsp_fcode;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  pgwalk dut_i (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] m_pde, m_pte;
  logic [31:0] rd_a [4];
  logic [31:0] wr_a [4];
  logic [31:0] wr_d [4];
  int n_rd = 0, n_wr = 0, lat = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_rd) begin
        if (lat == 0) begin
          if (n_rd < 4) rd_a[n_rd] = mem_addr;
          mem_rdata = (n_rd == 0) ? m_pde : m_pte;
          n_rd++;
          mem_rvalid = 1'b1;
          lat = int'($urandom % 3);
        end else lat--;
      end
      if (mem_wr) begin
        if (n_wr < 4) begin wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; end
        n_wr++;
      end
    end
  end

  function automatic logic denyf(input logic us, input logic rw, input logic u, input logic w, input logic wp);
    return (u && !us) || (w && !rw && (u || wp));
  endfunction

  task automatic run(input logic [31:0] va, input logic w, input logic u,
                     input logic [31:0] pde, input logic [31:0] pte,
                     input logic le, input logic wp, input string nm);
    logic [31:0] dir_a, tbl_a, e_pa;
    logic lg, e_flt, e_prot, e_wt, e_cd;
    int e_nrd, e_nwr, waited;
    logic [31:0] e_wa [2];
    logic [31:0] e_wd [2];
    dir_a = {cfg_dir_base[31:12], va[31:22], 2'b00};
    tbl_a = {pde[31:12], va[21:12], 2'b00};
    lg = pde[7] && le;
    e_flt = 0; e_prot = 0; e_pa = 0; e_wt = 0; e_cd = 0; e_nwr = 0;
    e_wa[0] = 0; e_wa[1] = 0; e_wd[0] = 0; e_wd[1] = 0;
    if (!pde[0]) begin e_nrd = 1; e_flt = 1; end
    else if (lg) begin
      e_nrd = 1;
      if (denyf(pde[2], pde[1], u, w, wp)) begin e_flt = 1; e_prot = 1; end
      else begin
        e_pa = {pde[31:22], va[21:0]}; e_wt = pde[3]; e_cd = pde[4];
        if (!pde[5]) begin e_wa[0] = dir_a; e_wd[0] = pde | 32'h20; e_nwr = 1; end
      end
    end else begin
      e_nrd = 2;
      if (!pte[0]) e_flt = 1;
      else if (denyf(pde[2] & pte[2], pde[1] & pte[1], u, w, wp)) begin e_flt = 1; e_prot = 1; end
      else begin
        e_pa = {pte[31:12], va[11:0]}; e_wt = pte[3]; e_cd = pte[4];
        if (!pde[5]) begin e_wa[e_nwr] = dir_a; e_wd[e_nwr] = pde | 32'h20; e_nwr++; end
        if (!pte[5]) begin e_wa[e_nwr] = tbl_a; e_wd[e_nwr] = pte | 32'h20; e_nwr++; end
      end
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    m_pde = pde; m_pte = pte; cfg_large_en = le; cfg_wp = wp;
    n_rd = 0; n_wr = 0;
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 100) begin @(negedge clk); waited++; end
    chk("R11", {nm, " response"}, 32'(rsp_valid), 32'd1);
    chk("R1", {nm, " dir addr"}, rd_a[0], dir_a);
    chk(lg ? "R3" : "R2", {nm, " read count"}, 32'(n_rd), 32'(e_nrd));
    if (e_nrd == 2 && n_rd >= 2) chk("R2", {nm, " tbl addr"}, rd_a[1], tbl_a);
    chk("R4/R5/R6", {nm, " fault"}, 32'(rsp_fault), 32'(e_flt));
    chk("R8", {nm, " fcode"}, 32'(rsp_fcode), e_flt ? 32'({u, w, e_prot}) : 32'd0);
    chk(lg ? "R3" : "R2", {nm, " paddr"}, rsp_paddr, e_pa);
    chk("R10", {nm, " attr"}, 32'({rsp_wt, rsp_cd}), 32'({e_wt, e_cd}));
    chk("R7", {nm, " wb count"}, 32'(n_wr), 32'(e_nwr));
    for (int i = 0; i < 2; i++) if (i < e_nwr && i < n_wr) begin
      chk("R7", {nm, " wb addr"}, wr_a[i], e_wa[i]);
      chk("R7", {nm, " wb data"}, wr_d[i], e_wd[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v, va, pde, pte;
    seed_v = $urandom(32'd4711);
    m_pde = 0; m_pte = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset ready", 32'(req_ready), 32'd1);
    chk("R11", "reset quiet", 32'({rsp_valid, mem_rd, mem_wr}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'h1234_5678, 0, 0, 32'h0040_1007, 32'h0ABC_D01F, 0, 0, "tbl both acc clear");
    run(32'h1234_5678, 0, 0, 32'h0040_1027, 32'h0ABC_D03F, 0, 0, "tbl both acc set");
    run(32'h8765_4321, 1, 1, 32'h0C00_0087, 32'h0, 1, 0, "R3 large page");
    run(32'h8765_4321, 1, 1, 32'h0C00_1087, 32'h0DEF_0007, 0, 0, "R3 large off walks tbl");
    run(32'h0000_1000, 1, 0, 32'hFFFF_FFFE, 32'h0, 1, 1, "R4 dir not present");
    run(32'h0000_1000, 1, 1, 32'h0040_1027, 32'hFFFF_FFFE, 0, 0, "R4 tbl not present");
    run(32'h0040_2ABC, 0, 1, 32'h0040_1023, 32'h0050_0027, 0, 0, "R5 dir not user");
    run(32'h0040_2ABC, 0, 1, 32'h0040_1027, 32'h0050_0023, 0, 0, "R5 tbl not user");
    run(32'h0040_2ABC, 0, 1, 32'h0C00_00A5, 32'h0, 1, 0, "R5 large user read");
    run(32'h0040_2ABC, 1, 0, 32'h0040_1025, 32'h0050_0027, 0, 0, "R6 sup write ro wp0");
    run(32'h0040_2ABC, 1, 0, 32'h0040_1025, 32'h0050_0027, 0, 1, "R6 sup write ro wp1");
    run(32'h0040_2ABC, 1, 1, 32'h0040_1027, 32'h0050_0025, 0, 0, "R6 user write ro");
    run(32'h0040_2ABC, 0, 1, 32'h0040_1E07, 32'h0050_0E1F, 0, 0, "R9 avail set");
    run(32'h0040_2ABC, 0, 1, 32'h0040_1007, 32'h0050_001F, 0, 0, "R9 avail clear");

    for (int n = 0; n < 400; n++) begin
      va = $urandom; pde = $urandom; pte = $urandom;
      if ($urandom % 6 != 0) pde[0] = 1'b1;
      if ($urandom % 6 != 0) pte[0] = 1'b1;
      if ($urandom % 2 == 0) begin pde[2:1] = 2'b11; pte[2:1] = 2'b11; end
      cfg_dir_base = {$urandom, 12'h0};
      run(va, 1'($urandom), 1'($urandom), pde, pte, 1'($urandom), 1'($urandom), "random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule